// File: doc/BRIEF.md
# Prescaled Auto-Reload Down-Counting Timer

This block is a software-programmed interval timer. Four registers reached through a simple write strobe and address port set it up: a control word, a prescale value, a reload period and the live count. While running, a prescaler divides the system clock by the prescale value plus one. Each time the prescaler wraps, the count steps down by one.

When a decrement takes the count from one to zero, the timer raises a one-cycle interrupt request and sets a sticky status bit, which software later clears. If auto-reload is on, the period value is copied into the count and counting goes on. If it is off, the count rests at zero until software writes a new value.

Clearing the enable bit or setting the low-power bit freezes the prescaler and the count where they stand. The block is meant to feed an interrupt controller, which sits outside it.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset all four registers read zero and the interrupt output is low.
- R2: While running, the count decrements once every (scale + 1) clocks. After the write that enables the timer, the first expiry comes N*(scale+1) clock edges later, where N is the loaded count.
- R3: Expiry is the decrement from 1 to 0. In the cycle after that edge the interrupt output is high for exactly one cycle, unless a new expiry follows at once.
- R4: With auto-reload on, expiry loads the period into the count. Each later expiry follows P*(scale+1) edges after the one before, where P is the period.
- R5: With auto-reload off, the count stays at 0 after expiry and no further interrupt occurs until software writes the count.
- R6: The sticky bit (control bit 3) is set on expiry and stays set. Writing 1 to bit 3 clears it and writing 0 leaves it unchanged. If an expiry and a clear fall in the same cycle, the bit ends up set.
- R7: With enable (control bit 0) low or low-power (control bit 1) high, the prescaler and count hold and no interrupt is produced.
- R8: A software write to the count takes priority over a decrement or reload in the same cycle, and it restarts the prescaler from zero.
- R9: Register map: address 0 is control (bit 0 enable, bit 1 low-power, bit 2 auto-reload, bit 3 sticky), address 1 is scale, address 2 is period and address 3 is count. Every register reads back what was written, except the sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for the register selected by addr (combinational) |
| irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
The embedded assertions check several behaviours on every cycle: the prescaler and count hold while stopped, a plain tick decrements by exactly one, expiry either reloads the period or parks the count at zero, the sticky bit is set on expiry and survives anything but a clear, and an interrupt needs a running timer. Other behaviours only the bench scenarios can show. These are the absolute timing from the enable write to the first expiry across swept scale and count values, the spacing between reloads, the set-over-clear collision, prescaler restart on a count write, and register read-back.

// File: rtl/tmr_pkg.sv
// Package: shared register addresses and control bit positions for the timer.
// Assumes a 2-bit register address space.
package tmr_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_SCALE  = 2'd1,
        REG_PERIOD = 2'd2,
        REG_COUNT  = 2'd3
    } tmr_addr_e;

    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_LP_BIT     = 1;
    localparam int CTRL_AUTO_BIT   = 2;
    localparam int CTRL_STICKY_BIT = 3;
    localparam int CTRL_W          = 4;
endpackage

// File: rtl/tmr_regs.sv
// Module: control, scale and period registers plus the sticky expiry flag.
// Assumes CNT_W >= SCALE_W and CNT_W >= 4. Sticky is set by hardware and cleared
// by writing 1; when both happen in one cycle, the set wins.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [CNT_W-1:0]   wdata,
    input  logic               expire,
    output logic               en,
    output logic               low_pwr,
    output logic               auto_rld,
    output logic               sticky,
    output logic               run,
    output logic               cnt_wr,
    output logic [SCALE_W-1:0] scale,
    output logic [CNT_W-1:0]   period
);
    logic ctrl_wr;

    // Decode write strobes per register.
    always_comb begin
        ctrl_wr = wr_en && (addr == REG_CTRL);
        cnt_wr  = wr_en && (addr == REG_COUNT);
    end

    // The timer advances only when enabled and not in low-power mode.
    assign run = en && !low_pwr;

    // Control bits that software owns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            low_pwr  <= 1'b0;
            auto_rld <= 1'b0;
        end else if (ctrl_wr) begin
            en       <= wdata[CTRL_EN_BIT];
            low_pwr  <= wdata[CTRL_LP_BIT];
            auto_rld <= wdata[CTRL_AUTO_BIT];
        end
    end

    // Sticky expiry flag: a hardware set beats a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky <= 1'b0;
        else if (expire)
            sticky <= 1'b1;
        else if (ctrl_wr && wdata[CTRL_STICKY_BIT])
            sticky <= 1'b0;
    end

    // Prescale value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scale <= '0;
        else if (wr_en && addr == REG_SCALE)
            scale <= wdata[SCALE_W-1:0];
    end

    // Reload period register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period <= '0;
        else if (wr_en && addr == REG_PERIOD)
            period <= wdata;
    end

    // R6: an expiry always leaves the flag set.
    a_r6_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sticky);
    // R6: without a clear write, the flag stays set.
    a_r6_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !(ctrl_wr && wdata[CTRL_STICKY_BIT])) |=> sticky);
endmodule

// File: rtl/tmr_prescaler.sv
// Module: divides the clock by scale+1 and emits one tick per wrap.
// Assumes scale may change at any time; a value above the new limit wraps at once.
module tmr_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    logic [SCALE_W-1:0] pre_q;

    // A tick fires when the running prescaler reaches its limit.
    assign tick = run && (pre_q >= scale);

    // Prescaler state: restart on a count write, hold while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (restart)
            pre_q <= '0;
        else if (run) begin
            if (pre_q >= scale)
                pre_q <= '0;
            else
                pre_q <= pre_q + 1'b1;
        end
    end

    // R7: the prescaler is frozen while the timer is stopped.
    a_r7_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(pre_q));
    // R8: a count write puts the prescaler back to zero.
    a_r8_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0));
endmodule

// File: rtl/tmr_counter.sv
// Module: the down-counter, the expiry detection, the reload and the interrupt pulse.
// Assumes tick arrives only while running. A software write wins over every other update.
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             auto_rld,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Expiry: a tick that takes the count from one to zero, unless software writes.
    assign expire = tick && !cnt_wr && (count == ONE);

    // Count register: write, then reload or park, then plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (cnt_wr)
            count <= wdata;
        else if (expire)
            count <= auto_rld ? period : '0;
        else if (tick && count != '0)
            count <= count - ONE;
    end

    // Interrupt request: one registered pulse per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= expire;
    end

    // R2: a plain tick steps the count down by exactly one.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count > ONE) |=> (count == $past(count) - ONE));
    // R4: an expiry with auto-reload loads the period.
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && auto_rld) |=> (count == $past(period)));
    // R5: an expiry without auto-reload parks the count at zero.
    a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !auto_rld) |=> (count == '0));
    // R7: without a tick or a write, the count holds.
    a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count));
    // R8: a written count lands regardless of tick or reload.
    a_r8_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wdata)));
endmodule

// File: rtl/prescaled_reload_timer.sv
// Module: top of the prescaled down-counting timer. Wires together the register
// file, the prescaler and the counter, and muxes the combinational read port.
// Assumes one register access per cycle through wr_en/addr/wdata.
module prescaled_reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SCALE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    logic               en, low_pwr, auto_rld, sticky, run, cnt_wr;
    logic               tick, expire;
    logic [SCALE_W-1:0] scale;
    logic [CNT_W-1:0]   period, count;

    tmr_regs #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .expire(expire), .en(en), .low_pwr(low_pwr), .auto_rld(auto_rld),
        .sticky(sticky), .run(run), .cnt_wr(cnt_wr), .scale(scale), .period(period)
    );

    tmr_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(cnt_wr),
        .scale(scale), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .wdata(wdata),
        .auto_rld(auto_rld), .period(period), .count(count),
        .expire(expire), .irq(irq)
    );

    // Read mux: the selected register, zero-extended.
    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CTRL: begin
                rdata[CTRL_EN_BIT]     = en;
                rdata[CTRL_LP_BIT]     = low_pwr;
                rdata[CTRL_AUTO_BIT]   = auto_rld;
                rdata[CTRL_STICKY_BIT] = sticky;
            end
            REG_SCALE:  rdata[SCALE_W-1:0] = scale;
            REG_PERIOD: rdata = period;
            default:    rdata = count;
        endcase
    end

    // R7: an interrupt only follows a cycle in which the timer ran.
    a_r7_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run));
    // R3: an interrupt always comes with the sticky flag set.
    a_r3_irq_flags: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sticky);
endmodule

// File: tb/prescaled_reload_timer_tb.sv
module prescaled_reload_timer_tb;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       addr = 2'd0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic             irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    prescaled_reload_timer #(.CNT_W(CNT_W), .SCALE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    // Edges from now until irq is seen high (or limit).
    task automatic wait_irq(input int limit, output int k);
        k = 0;
        do begin
            @(posedge clk); #1; k++;
        end while (!irq && k < limit);
    endtask

    task automatic setup(input int s, input int n, input int p);
        wr(2'd0, 32'h8);          // stop and clear sticky
        wr(2'd1, s);
        wr(2'd2, p);
        wr(2'd3, n);              // count write also restarts prescaler
    endtask

    initial begin
        logic [31:0] v;
        int k, k2, pulses;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset irq", irq, 0);

        // R9: register read-back
        wr(2'd1, 32'hA5); rd(2'd1, v); chk("R9 scale", v, 32'hA5);
        wr(2'd2, 32'h12345678); rd(2'd2, v); chk("R9 period", v, 32'h12345678);
        wr(2'd3, 32'hCAFE); rd(2'd3, v); chk("R9 count", v, 32'hCAFE);
        wr(2'd0, 32'h6); rd(2'd0, v); chk("R9 ctrl", v, 32'h6);

        // R2/R3/R5/R6: sweep scale and count without auto-reload
        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n <= 5; n++) begin
                setup(s, n, 0);
                wr(2'd0, 32'h1);
                wait_irq(200, k);
                chk("R2 first expiry timing", k, n * (s + 1));
                rd(2'd0, v); chk("R6 sticky set", v[3], 1);
                @(posedge clk); #1;
                chk("R3 single pulse", irq, 0);
                pulses = 0;
                repeat (3 * (s + 1) + 4) begin
                    @(posedge clk); #1;
                    if (irq) pulses++;
                end
                chk("R5 no further irq", pulses, 0);
                rd(2'd3, v); chk("R5 count parked", v, 0);
                wr(2'd0, 32'h1); rd(2'd0, v); chk("R6 write 0 keeps sticky", v[3], 1);
                wr(2'd0, 32'h9); rd(2'd0, v); chk("R6 write 1 clears", v[3], 0);
            end
        end

        // R4: auto-reload spacing
        for (int s = 0; s < 3; s++) begin
            for (int p = 1; p <= 4; p++) begin
                setup(s, 3, p);
                wr(2'd0, 32'h5);
                wait_irq(200, k);
                chk("R4 first expiry", k, 3 * (s + 1));
                wait_irq(200, k2);
                chk("R4 reload spacing", k2, p * (s + 1));
                wait_irq(200, k2);
                chk("R4 reload spacing 2", k2, p * (s + 1));
            end
        end

        // R6: set beats clear in the same cycle
        setup(0, 3, 0);
        wr(2'd0, 32'h1);
        repeat (2) @(posedge clk);
        wr(2'd0, 32'h9);          // lands on the expiry edge
        chk("R6 collision irq", irq, 1);
        rd(2'd0, v); chk("R6 collision sticky", v[3], 1);

        // R7: disabled and low-power hold
        setup(1, 10, 0);
        pulses = 0;
        repeat (20) begin @(posedge clk); #1; if (irq) pulses++; end
        rd(2'd3, v); chk("R7 disabled hold", v, 10);
        wr(2'd0, 32'h3);
        repeat (20) begin @(posedge clk); #1; if (irq) pulses++; end
        rd(2'd3, v); chk("R7 low-power hold", v, 10);
        chk("R7 no irq when stopped", pulses, 0);
        wr(2'd0, 32'h1);
        wait_irq(200, k);
        chk("R7 resume timing", k, 20);

        // R8: write beats decrement
        setup(0, 5, 0);
        wr(2'd0, 32'h1);
        wr(2'd3, 7);
        rd(2'd3, v); chk("R8 write wins", v, 7);
        wait_irq(200, k);
        chk("R8 timing after write", k, 7);

        // R8: write restarts prescaler
        setup(3, 2, 0);
        wr(2'd0, 32'h1);
        @(posedge clk);
        wr(2'd3, 2);
        wait_irq(200, k);
        chk("R8 prescaler restart", k, 8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule